// File: doc/BRIEF.md
# Descriptor-Chain Image Streaming DMA

This engine moves enrolled images from a database memory onto a streaming source port. Software places a chain of three-word descriptors in a configuration memory. Each descriptor gives a link to the next descriptor, the start word address of one image, and that image's length in words. Software then gives the pointer of the first descriptor and pulses `start`. The engine walks the chain with no further help. It emits every image as one packet, with a start marker on the first word and an end marker on the last word. Software finds out that the chain is finished by polling `done`.

Descriptors are fetched through their own read port, separate from the image reads. While the current image is streaming, the next descriptor is read and parked in a holding register. The reader can therefore jump from the last word of one image to the first word of the next in the same cycle. Both memory ports have a fixed read latency of one cycle. A small output FIFO absorbs that latency. The FIFO also lets the read address freeze when the sink applies backpressure.

The control is split into three state machines:

- **Top sequencer.** It has the states `T_IDLE` and `T_ACTIVE`. *accept* moves `T_IDLE` to `T_ACTIVE` when `start` is high. *finish* moves `T_ACTIVE` back to `T_IDLE` when the chain is exhausted, the reader is idle and nothing is left in flight or queued.
- **Descriptor fetcher.** It has the states `F_IDLE`, `F_RD_NEXT`, `F_RD_ADDR`, `F_RD_LEN`, `F_CAPTURE`, `F_HOLD` and `F_LAST`.
  - *launch*: from `F_IDLE` or `F_LAST` to `F_RD_NEXT` on a go with a non-zero pointer.
  - *empty*: from `F_IDLE` or `F_LAST` to `F_LAST` on a go with a zero pointer.
  - *step*: `F_RD_NEXT` to `F_RD_ADDR` to `F_RD_LEN` to `F_CAPTURE` to `F_HOLD`.
  - *follow*: from `F_HOLD` to `F_RD_NEXT` when the parked descriptor is taken and its link is non-zero.
  - *end*: from `F_HOLD` to `F_LAST` when the parked descriptor is taken and its link is zero.
- **Image reader.** It has the states `R_IDLE` and `R_RUN`.
  - *load*: from `R_IDLE` to `R_RUN` when a descriptor is parked.
  - *chain-on*: stays in `R_RUN` when the last word is issued and a descriptor is parked.
  - *drain*: from `R_RUN` to `R_IDLE` when the last word is issued and nothing is parked.

Top module: `chain_stream_dma`

## Requirements
- R1: After reset `busy`, `done`, `src_valid`, `dsc_rd_en` and `img_rd_en` are all 0.
- R2: A `start` pulse seen while idle raises `busy` and clears `done` at that clock edge. The first three descriptor reads then go to `head_ptr`, `head_ptr+1` and `head_ptr+2`, in that order. These words hold the link, the image start address and the image length, at offsets 0, 1 and 2.
- R3: Each descriptor with start address A and length L (L at least 1) yields exactly L stream words. Word k carries the database word at address A+k. Images follow chain order.
- R4: `src_sop` is 1 only on word 0 of each image and `src_eop` is 1 only on word L-1. An image of length 1 carries both markers on its single word.
- R5: A link value of 0 ends the chain. A head pointer of 0 is an empty chain: no word is emitted and `done` is set.
- R6: While `src_valid` is 1 and `src_ready` is 0, `src_valid`, `src_data`, `src_sop` and `src_eop` hold their values into the next cycle. No word is dropped or repeated.
- R7: With `src_ready` held at 1 and every image at least 5 words long, `src_valid` stays 1 from the first word of the chain to its last word. There is no idle cycle at any image boundary.
- R8: A `start` pulse while `busy` is 1 is ignored. The running chain and its word sequence are unchanged, and no second chain follows.
- R9: `done` becomes 1, and `busy` becomes 0, after the last word has been accepted. `done` then holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking the chain at `head_ptr` |
| head_ptr | input | DESC_AW | Address of the first descriptor (0 = empty chain) |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | Last chain finished; cleared by an accepted start |
| dsc_rd_en | output | 1 | Descriptor memory read strobe |
| dsc_rd_addr | output | DESC_AW | Descriptor memory word address |
| dsc_rd_data | input | DESC_DW | Descriptor word, one cycle after the strobe |
| img_rd_en | output | 1 | Database memory read strobe |
| img_rd_addr | output | ADDR_W | Database memory word address |
| img_rd_data | input | DATA_W | Database word, one cycle after the strobe |
| src_valid | output | 1 | Stream word is present |
| src_ready | input | 1 | Sink accepts the word this cycle |
| src_data | output | DATA_W | Stream word |
| src_sop | output | 1 | First word of an image |
| src_eop | output | 1 | Last word of an image |

## Verification
The assertions take two things for granted. Both memories answer exactly one cycle after a read strobe. Every descriptor in a chain has a length of at least one word. The stimulus respects both rules: the bench memory models are plain registered reads, and every descriptor it writes has a length between 1 and 9. The gap-free property is claimed, and checked, only for chains whose images are at least 5 words long with the sink always ready. Shorter images appear only in runs with backpressure or in single-image chains. The bench never places a descriptor at address 0, because that value means end of chain.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    // Word offsets inside a descriptor; the fetcher reads them in this order.
    localparam int unsigned DSC_OFS_LINK = 0;
    localparam int unsigned DSC_OFS_ADDR = 1;
    localparam int unsigned DSC_OFS_LEN  = 2;

    typedef enum logic [2:0] {
        F_IDLE,
        F_RD_NEXT,
        F_RD_ADDR,
        F_RD_LEN,
        F_CAPTURE,
        F_HOLD,
        F_LAST
    } fetch_state_t;

    typedef enum logic {
        R_IDLE,
        R_RUN
    } read_state_t;

    typedef enum logic {
        T_IDLE,
        T_ACTIVE
    } top_state_t;

endpackage

// File: rtl/cdma_desc_fetch.sv
module cdma_desc_fetch
    import cdma_pkg::*;
#(
    parameter int DESC_AW = 16,
    parameter int DESC_DW = 16,
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [DESC_AW-1:0] go_ptr,
    input  logic               take,
    output logic               dsc_rd_en,
    output logic [DESC_AW-1:0] dsc_rd_addr,
    input  logic [DESC_DW-1:0] dsc_rd_data,
    output logic               pend_valid,
    output logic [ADDR_W-1:0]  pend_addr,
    output logic [LEN_W-1:0]   pend_len,
    output logic               chain_end
);

    fetch_state_t       state, state_d;
    logic [DESC_AW-1:0] ptr;
    logic [DESC_AW-1:0] link;

    // next-state and read-port outputs
    always_comb begin
        state_d     = state;
        dsc_rd_en   = 1'b0;
        dsc_rd_addr = ptr;
        unique case (state)
            F_IDLE, F_LAST: begin
                if (go) state_d = (go_ptr == '0) ? F_LAST : F_RD_NEXT;
            end
            F_RD_NEXT: begin
                dsc_rd_en   = 1'b1;
                dsc_rd_addr = ptr + DESC_AW'(DSC_OFS_LINK);
                state_d     = F_RD_ADDR;
            end
            F_RD_ADDR: begin
                dsc_rd_en   = 1'b1;
                dsc_rd_addr = ptr + DESC_AW'(DSC_OFS_ADDR);
                state_d     = F_RD_LEN;
            end
            F_RD_LEN: begin
                dsc_rd_en   = 1'b1;
                dsc_rd_addr = ptr + DESC_AW'(DSC_OFS_LEN);
                state_d     = F_CAPTURE;
            end
            F_CAPTURE: state_d = F_HOLD;
            F_HOLD: begin
                if (take) state_d = (link == '0) ? F_LAST : F_RD_NEXT;
            end
            default: state_d = F_IDLE;
        endcase
    end

    assign pend_valid = (state == F_HOLD);
    assign chain_end  = (state == F_LAST);

    // state register and captured descriptor fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= F_IDLE;
            ptr       <= '0;
            link      <= '0;
            pend_addr <= '0;
            pend_len  <= '0;
        end else begin
            state <= state_d;
            if ((state == F_IDLE || state == F_LAST) && go) ptr <= go_ptr;
            if (state == F_HOLD && take)                    ptr <= link;
            // each word returns one cycle after its read
            if (state == F_RD_ADDR) link      <= dsc_rd_data[DESC_AW-1:0];
            if (state == F_RD_LEN)  pend_addr <= dsc_rd_data[ADDR_W-1:0];
            if (state == F_CAPTURE) pend_len  <= dsc_rd_data[LEN_W-1:0];
        end
    end

    // R2: link, address and length words are read at consecutive addresses
    p_desc_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_RD_NEXT) |=> dsc_rd_en && dsc_rd_addr == $past(dsc_rd_addr) + DESC_AW'(1));

    // R3: a parked descriptor does not change until it is taken
    p_park_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid && !take |=> pend_valid && $stable(pend_addr) && $stable(pend_len));

endmodule

// File: rtl/cdma_img_reader.sv
module cdma_img_reader
    import cdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [LEN_W-1:0]  pend_len,
    input  logic              room,
    output logic              take,
    output logic              img_rd_en,
    output logic [ADDR_W-1:0] img_rd_addr,
    output logic              iss_sop,
    output logic              iss_eop,
    output logic              running
);

    read_state_t       state, state_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic              first;
    logic              issue;
    logic              last_word;

    assign last_word = (remain == LEN_W'(1));

    always_comb begin
        state_d = state;
        take    = 1'b0;
        issue   = 1'b0;
        unique case (state)
            R_IDLE: begin
                if (pend_valid) begin
                    take    = 1'b1;
                    state_d = R_RUN;
                end
            end
            R_RUN: begin
                if (room) begin
                    issue = 1'b1;
                    if (last_word) begin
                        if (pend_valid) take    = 1'b1;   // chain-on, no gap
                        else            state_d = R_IDLE;
                    end
                end
            end
            default: state_d = R_IDLE;
        endcase
    end

    assign img_rd_en   = issue;
    assign img_rd_addr = cur_addr;
    assign iss_sop     = issue && first;
    assign iss_eop     = issue && last_word;
    assign running     = (state == R_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= R_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            first    <= 1'b0;
        end else begin
            state <= state_d;
            if (take) begin
                cur_addr <= pend_addr;
                remain   <= pend_len;
                first    <= 1'b1;
            end else if (issue) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                remain   <= remain - LEN_W'(1);
                first    <= 1'b0;
            end
        end
    end

    // R3: inside one image the read address steps by one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        img_rd_en && !iss_eop |=> !img_rd_en || img_rd_addr == $past(img_rd_addr) + ADDR_W'(1));

    // R3: a descriptor is only taken when one is parked
    p_take_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_valid);

endmodule

// File: rtl/cdma_out_fifo.sv
module cdma_out_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_data = store[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R6: a returning word always finds a free slot
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)) || pop);

    // R6: nothing is popped from an empty queue
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);

endmodule

// File: rtl/chain_stream_dma.sv
module chain_stream_dma
    import cdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int DESC_AW    = 16,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 2,
    parameter int DESC_DW    = (ADDR_W > LEN_W)
                             ? ((ADDR_W > DESC_AW) ? ADDR_W : DESC_AW)
                             : ((LEN_W > DESC_AW) ? LEN_W : DESC_AW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DESC_AW-1:0] head_ptr,
    output logic               busy,
    output logic               done,
    output logic               dsc_rd_en,
    output logic [DESC_AW-1:0] dsc_rd_addr,
    input  logic [DESC_DW-1:0] dsc_rd_data,
    output logic               img_rd_en,
    output logic [ADDR_W-1:0]  img_rd_addr,
    input  logic [DATA_W-1:0]  img_rd_data,
    output logic               src_valid,
    input  logic               src_ready,
    output logic [DATA_W-1:0]  src_data,
    output logic               src_sop,
    output logic               src_eop
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int TAG_W = DATA_W + 2;

    top_state_t         state, state_d;
    logic               go;
    logic               finish;
    logic               pend_valid, take, chain_end, running, room;
    logic [ADDR_W-1:0]  pend_addr;
    logic [LEN_W-1:0]   pend_len;
    logic               iss_sop, iss_eop;
    logic               fly_valid, fly_sop, fly_eop;
    logic               pop;
    logic [CNT_W-1:0]   q_count;
    logic [TAG_W-1:0]   q_head;
    logic [CNT_W:0]     occupancy, limit;

    // sequencer: next state
    always_comb begin
        state_d = state;
        go      = 1'b0;
        finish  = 1'b0;
        unique case (state)
            T_IDLE: begin
                if (start) begin
                    go      = 1'b1;
                    state_d = T_ACTIVE;
                end
            end
            T_ACTIVE: begin
                if (chain_end && !running && !fly_valid && q_count == '0) begin
                    finish  = 1'b1;
                    state_d = T_IDLE;
                end
            end
            default: state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            if (go)          done <= 1'b0;
            else if (finish) done <= 1'b1;
        end
    end

    assign busy = (state == T_ACTIVE);

    cdma_desc_fetch #(
        .DESC_AW (DESC_AW),
        .DESC_DW (DESC_DW),
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .go_ptr      (head_ptr),
        .take        (take),
        .dsc_rd_en   (dsc_rd_en),
        .dsc_rd_addr (dsc_rd_addr),
        .dsc_rd_data (dsc_rd_data),
        .pend_valid  (pend_valid),
        .pend_addr   (pend_addr),
        .pend_len    (pend_len),
        .chain_end   (chain_end)
    );

    // issue only if the word can be queued when it returns
    assign pop       = src_valid && src_ready;
    assign occupancy = {1'b0, q_count} + (CNT_W+1)'(fly_valid);
    assign limit     = (CNT_W+1)'(FIFO_DEPTH) + (CNT_W+1)'(pop);
    assign room      = occupancy < limit;

    cdma_img_reader #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_valid  (pend_valid),
        .pend_addr   (pend_addr),
        .pend_len    (pend_len),
        .room        (room),
        .take        (take),
        .img_rd_en   (img_rd_en),
        .img_rd_addr (img_rd_addr),
        .iss_sop     (iss_sop),
        .iss_eop     (iss_eop),
        .running     (running)
    );

    // markers travel beside the one-cycle memory read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fly_valid <= 1'b0;
            fly_sop   <= 1'b0;
            fly_eop   <= 1'b0;
        end else begin
            fly_valid <= img_rd_en;
            fly_sop   <= iss_sop;
            fly_eop   <= iss_eop;
        end
    end

    cdma_out_fifo #(
        .WIDTH (TAG_W),
        .DEPTH (FIFO_DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fly_valid),
        .push_data ({fly_sop, fly_eop, img_rd_data}),
        .pop       (pop),
        .head_data (q_head),
        .count     (q_count)
    );

    assign src_valid = (q_count != '0);
    assign src_sop   = q_head[TAG_W-1];
    assign src_eop   = q_head[TAG_W-2];
    assign src_data  = q_head[DATA_W-1:0];

    // R1: no memory traffic and no stream word while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dsc_rd_en && !img_rd_en && !src_valid);

    // R6: a stalled word holds
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid && !src_ready |=> src_valid && $stable(src_data) && $stable(src_sop) && $stable(src_eop));

    // R9: done and busy never overlap
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: start during a run does not clear done or end the run early
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !finish |=> busy && !done);

endmodule

// File: tb/chain_stream_dma_tb.sv
`timescale 1ns/1ps
module chain_stream_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  head_ptr = '0;
    logic        busy, done;
    logic        dsc_rd_en;
    logic [5:0]  dsc_rd_addr;
    logic [7:0]  dsc_rd_data;
    logic        img_rd_en;
    logic [7:0]  img_rd_addr;
    logic [15:0] img_rd_data;
    logic        src_valid;
    logic        src_ready = 1'b1;
    logic [15:0] src_data;
    logic        src_sop, src_eop;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    chain_stream_dma #(
        .ADDR_W     (8),
        .DATA_W     (16),
        .DESC_AW    (6),
        .LEN_W      (8),
        .FIFO_DEPTH (2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .head_ptr    (head_ptr),
        .busy        (busy),
        .done        (done),
        .dsc_rd_en   (dsc_rd_en),
        .dsc_rd_addr (dsc_rd_addr),
        .dsc_rd_data (dsc_rd_data),
        .img_rd_en   (img_rd_en),
        .img_rd_addr (img_rd_addr),
        .img_rd_data (img_rd_data),
        .src_valid   (src_valid),
        .src_ready   (src_ready),
        .src_data    (src_data),
        .src_sop     (src_sop),
        .src_eop     (src_eop)
    );

    // memory models: registered reads, one cycle latency
    logic [7:0] dsc_mem [0:63];

    function automatic logic [15:0] img_val(input logic [7:0] a);
        return {a ^ 8'hC3, a + 8'd17};
    endfunction

    always @(posedge clk) begin
        dsc_rd_data <= dsc_mem[dsc_rd_addr];
        img_rd_data <= img_val(img_rd_addr);
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic put_desc(input logic [5:0] p, input logic [7:0] nx,
                            input logic [7:0] a, input logic [7:0] l);
        dsc_mem[p]      = nx;
        dsc_mem[p + 1]  = a;
        dsc_mem[p + 2]  = l;
    endtask

    logic [15:0] exp_d [0:511];
    logic        exp_s [0:511];
    logic        exp_e [0:511];
    int          exp_n;

    // expected stream from the descriptors as written
    task automatic build(input logic [5:0] head);
        logic [5:0] p;
        int guard;
        exp_n = 0;
        p = head;
        guard = 0;
        while (p != 0 && guard < 20) begin
            for (int k = 0; k < int'(dsc_mem[p + 2]); k++) begin
                exp_d[exp_n] = img_val(dsc_mem[p + 1] + 8'(k));
                exp_s[exp_n] = (k == 0);
                exp_e[exp_n] = (k == int'(dsc_mem[p + 2]) - 1);
                exp_n++;
            end
            p = dsc_mem[p][5:0];
            guard++;
        end
    endtask

    logic [7:0] lfsr = 8'hA5;

    function automatic logic ready_for(input int mode, input int cyc, input logic [7:0] r);
        if (mode == 0) return 1'b1;
        if (mode == 1) return r[0] | r[3];
        return (cyc % 3) != 1;
    endfunction

    task automatic run_chain(input logic [5:0] head, input int mode, input int inj_cyc,
                             input logic [5:0] inj_ptr, input logic gap_chk);
        int idx = 0, extra = 0, gaps = 0, cyc = 0, nrd = 0;
        logic stall_prev = 1'b0;
        logic [15:0] d_prev = '0;
        logic s_prev = 1'b0, e_prev = 1'b0;
        logic [5:0] rdseq [3];
        build(head);
        @(negedge clk);
        head_ptr  = head;
        start     = 1'b1;
        src_ready = ready_for(mode, cyc, lfsr);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R9 done cleared by start", int'(done), 0);
        forever begin
            if (stall_prev)
                chk(src_valid && src_data == d_prev && src_sop == s_prev && src_eop == e_prev,
                    "R6 stalled word held", int'(src_data), int'(d_prev));
            if (gap_chk && idx > 0 && idx < exp_n && !src_valid) gaps++;
            if (dsc_rd_en && nrd < 3) begin
                rdseq[nrd] = dsc_rd_addr;
                nrd++;
            end
            if (src_valid && src_ready) begin
                if (idx < exp_n) begin
                    chk(src_data == exp_d[idx], "R3 word value", int'(src_data), int'(exp_d[idx]));
                    chk(src_sop == exp_s[idx] && src_eop == exp_e[idx], "R4 packet markers",
                        int'({src_sop, src_eop}), int'({exp_s[idx], exp_e[idx]}));
                    idx++;
                end else extra++;
            end
            stall_prev = src_valid && !src_ready;
            d_prev = src_data;
            s_prev = src_sop;
            e_prev = src_eop;
            if (done) break;
            if (cyc > 4000) begin
                chk(1'b0, "R9 run did not complete", cyc, 0);
                break;
            end
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            src_ready = ready_for(mode, cyc, lfsr);
            if (cyc == inj_cyc) begin
                start    = 1'b1;
                head_ptr = inj_ptr;
            end else start = 1'b0;
            #1;
        end
        start = 1'b0;
        if (head != 0)
            chk(nrd == 3 && rdseq[0] == head && rdseq[1] == head + 1 && rdseq[2] == head + 2,
                "R2 descriptor read order", int'(rdseq[1]), int'(head + 1));
        chk(idx == exp_n, "R3 word count", idx, exp_n);
        chk(extra == 0, "R8 no surplus words", extra, 0);
        if (gap_chk) chk(gaps == 0, "R7 idle cycles inside chain", gaps, 0);
        chk(busy == 1'b0, "R9 busy cleared at finish", int'(busy), 0);
        src_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(done == 1'b1 && busy == 1'b0, "R9 done holds", int'(done), 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dsc_mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !done && !src_valid && !dsc_rd_en && !img_rd_en,
            "R1 reset outputs", int'({busy, done, src_valid, dsc_rd_en, img_rd_en}), 0);
        rst_n = 1'b1;

        // chain A: three images >= 5 words, sink always ready (R3, R4, R7)
        put_desc(6'd4,  8'd12, 8'd10,  8'd5);
        put_desc(6'd12, 8'd20, 8'd40,  8'd7);
        put_desc(6'd20, 8'd0,  8'd100, 8'd6);
        run_chain(6'd4, 0, -1, 6'd0, 1'b1);

        // chain B: short images under backpressure (R4 length one, R6)
        put_desc(6'd30, 8'd36, 8'd200, 8'd1);
        put_desc(6'd36, 8'd42, 8'd150, 8'd2);
        put_desc(6'd42, 8'd0,  8'd77,  8'd3);
        run_chain(6'd30, 1, -1, 6'd0, 1'b0);
        run_chain(6'd30, 2, -1, 6'd0, 1'b0);

        // R5: empty chain
        run_chain(6'd0, 0, -1, 6'd0, 1'b0);

        // R8: start pulse during a run is ignored
        run_chain(6'd4, 0, 8, 6'd30, 1'b1);
        run_chain(6'd4, 1, 5, 6'd30, 1'b0);

        // sweep: single image lengths 1..9 under each sink pattern
        for (int l = 1; l <= 9; l++) begin
            for (int m = 0; m < 3; m++) begin
                put_desc(6'd50, 8'd0, 8'(l * 13), 8'(l));
                run_chain(6'd50, m, -1, 6'd0, m == 0);
            end
        end

        // sweep: two-image chains of 5..8 words, always ready (R7)
        for (int a = 5; a <= 8; a++) begin
            for (int b = 5; b <= 8; b++) begin
                put_desc(6'd54, 8'd58, 8'(a * 9), 8'(a));
                put_desc(6'd58, 8'd0,  8'(160 + b), 8'(b));
                run_chain(6'd54, 0, -1, 6'd0, 1'b1);
            end
        end

        summary();
        $finish;
    end

endmodule